// File: doc/BRIEF.md
# Effective address generation unit

This unit turns a decoded addressing-mode code, two register read values and an instruction constant into the operand location that an instruction needs. Depending on the mode, the result is the register contents themselves, an immediate value, or an effective address. The address can come from the constant, from a register, from a register moved up or down by a step, from a base-plus-index-plus-displacement sum, or from a word read from memory. For the auto-modify modes the unit also returns the value to write back to the address register, in the same cycle as the address.

One control bit selects the address width for each request. When it is clear, every generated address keeps only its low 24 bits. When it is set, every generated address keeps its low 31 bits. Masking is the last step, applied after all additions and after any memory fetch, so bit 31 of an address result is always zero. The memory-indirect mode drives a read port with a valid/ready handshake. The unit accepts no new request until that read completes. Every other mode returns its result in the cycle after it is accepted.

Top module: `ea_gen_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `wb_en` and `mem_rd_valid` are 0 and `req_ready` is 1.
- R2: Mode code 0 (register) returns `res_kind`=0 with `res_value` equal to `reg_a`, unmasked. Codes 10 to 15 behave the same way. No write-back is signalled.
- R3: Mode code 1 (immediate) returns `res_kind`=1 with `res_value` equal to `konst`, unmasked.
- R4: Mode code 2 (absolute) returns `res_kind`=2 with `res_value` equal to the masked `konst`.
- R5: Mode code 3 (register indirect) returns `res_kind`=2 with `res_value` equal to the masked `reg_a`.
- R6: The address mask keeps bits 23:0 when `req_wide`=0 and bits 30:0 when `req_wide`=1. It applies to every result with `res_kind`=2 and to every write-back value. Bit 31 of such results is always 0.
- R7: Pre-modify codes 5 (add) and 6 (subtract) compute the masked value `reg_a` ± step. That value is returned both as the address and as `wb_value`, with `wb_en`=1.
- R8: Post-modify codes 7 (add) and 8 (subtract) return the masked `reg_a` as the address and the masked `reg_a` ± step as `wb_value`, with `wb_en`=1.
- R9: The step is 4 when `req_step_sel`=0 and `konst` when `req_step_sel`=1.
- R10: Mode code 9 (indexed) returns the masked value of `reg_a` + `konst`, plus `reg_b` only when `req_use_index`=1.
- R11: Mode code 4 (memory indirect) raises `mem_rd_valid` in the cycle after acceptance, with `mem_rd_addr` equal to the masked `konst`. Both stay held until `mem_rd_ready`=1. In the cycle after that, the result is `res_kind`=2 with the masked `mem_rd_data`.
- R12: A request is accepted when `req_valid` and `req_ready` are both 1. `res_valid` is high for one cycle per request, in the cycle after acceptance for every mode except code 4. `req_ready` stays 0 while a memory read is pending, and requests presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing-mode code |
| req_wide | input | 1 | 0: 24-bit addresses, 1: 31-bit addresses |
| req_step_sel | input | 1 | Auto-modify step source: 0 fixed, 1 constant |
| req_use_index | input | 1 | Add the index register in indexed mode |
| reg_a | input | 32 | Base or address register value |
| reg_b | input | 32 | Index register value |
| konst | input | 32 | Instruction constant |
| mem_rd_valid | output | 1 | Indirect read request |
| mem_rd_addr | output | 32 | Indirect read address |
| mem_rd_ready | input | 1 | Read done, data valid this cycle |
| mem_rd_data | input | 32 | Word read from memory |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 register, 1 immediate, 2 address |
| res_value | output | 32 | Operand or effective address |
| wb_en | output | 1 | Register write-back strobe |
| wb_value | output | 32 | Write-back value |

## Verification
Two events share one cycle here. In the auto-modify modes, the address result and the register write-back are emitted together. In the memory-indirect mode, a new request can sit at the input while the read is still pending. The sweep covers every mode code at both widths and with both step sources. Its operands lie at the 24-bit and 31-bit wrap points, so the address and the write-back value are each compared with arithmetic done in the bench. During every indirect fetch the bench holds a register-mode request active and requires that no extra result appears. The fetch result must then arrive exactly one cycle after the read completes.

// File: rtl/ea_gen_pkg.sv
// Package: shared encodings of the effective address unit.
// Assumes: 4-bit mode codes and a 2-bit result kind.
package ea_gen_pkg;
    localparam int MODE_W = 4;
    localparam int KIND_W = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_REG     = 4'd0,
        AM_IMM     = 4'd1,
        AM_ABS     = 4'd2,
        AM_RIND    = 4'd3,
        AM_MIND    = 4'd4,
        AM_PREINC  = 4'd5,
        AM_PREDEC  = 4'd6,
        AM_POSTINC = 4'd7,
        AM_POSTDEC = 4'd8,
        AM_INDEX   = 4'd9
    } am_mode_e;

    localparam logic [KIND_W-1:0] RK_REG = 2'd0;
    localparam logic [KIND_W-1:0] RK_IMM = 2'd1;
    localparam logic [KIND_W-1:0] RK_EA  = 2'd2;
endpackage

// File: rtl/ea_mask.sv
// Module: ea_mask
// Clears the high bits of an address so that it has NARROW_W or WIDE_W
// significant bits. Assumes NARROW_W < WIDE_W <= DW.
module ea_mask #(
    parameter int DW       = 32,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31
) (
    input  logic          wide,
    input  logic [DW-1:0] in,
    output logic [DW-1:0] out
);
    localparam logic [DW-1:0] NMASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [DW-1:0] wmask;

    // Choose the wide mask; a full-width WIDE_W means no clearing at all.
    generate
        if (WIDE_W >= DW) begin : g_full
            assign wmask = '1;
        end else begin : g_part
            assign wmask = {{(DW-WIDE_W){1'b0}}, {WIDE_W{1'b1}}};
        end
    endgenerate

    // Apply the mask that the width bit selects.
    assign out = in & (wide ? wmask : NMASK);
endmodule

// File: rtl/ea_calc.sv
// Module: ea_calc
// Combinational part of the unit: it forms the result kind, the value,
// the write-back value and the fetch pointer for one request.
// Assumes: the mode code is stable while the request is presented.
module ea_calc
    import ea_gen_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31,
    parameter int STEP     = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              wide,
    input  logic              step_sel,
    input  logic              use_index,
    input  logic [DW-1:0]     reg_a,
    input  logic [DW-1:0]     reg_b,
    input  logic [DW-1:0]     konst,
    output logic [KIND_W-1:0] kind,
    output logic [DW-1:0]     value,
    output logic              wb_en,
    output logic [DW-1:0]     wb_value,
    output logic              is_fetch,
    output logic [DW-1:0]     fetch_addr
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);

    logic [DW-1:0] step_v;
    logic [DW-1:0] moved;
    logic [DW-1:0] idx_sum;
    logic [DW-1:0] pick;
    logic [DW-1:0] pick_m;
    logic [DW-1:0] moved_m;
    logic          down;

    // Step source and direction of the auto-modify arithmetic.
    assign step_v  = step_sel ? konst : STEP_V;
    assign down    = (mode == AM_PREDEC) || (mode == AM_POSTDEC);
    assign moved   = down ? (reg_a - step_v) : (reg_a + step_v);
    assign idx_sum = reg_a + (use_index ? reg_b : '0) + konst;

    // Unmasked address chosen for each address-producing mode.
    always_comb begin
        unique case (mode)
            AM_ABS, AM_MIND:         pick = konst;
            AM_PREINC, AM_PREDEC:    pick = moved;
            AM_INDEX:                pick = idx_sum;
            default:                 pick = reg_a;
        endcase
    end

    ea_mask #(.DW(DW), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_pick_mask (
        .wide (wide),
        .in   (pick),
        .out  (pick_m)
    );

    ea_mask #(.DW(DW), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_wb_mask (
        .wide (wide),
        .in   (moved),
        .out  (moved_m)
    );

    // Result kind, value and write-back for the presented mode.
    always_comb begin
        kind     = RK_EA;
        value    = pick_m;
        wb_en    = 1'b0;
        wb_value = moved_m;
        is_fetch = 1'b0;
        case (mode)
            AM_IMM: begin
                kind  = RK_IMM;
                value = konst;
            end
            AM_ABS, AM_RIND, AM_INDEX: ;
            AM_MIND: is_fetch = 1'b1;
            AM_PREINC, AM_PREDEC, AM_POSTINC, AM_POSTDEC: wb_en = 1'b1;
            default: begin
                kind  = RK_REG;
                value = reg_a;
            end
        endcase
    end

    assign fetch_addr = pick_m;
endmodule

// File: rtl/ea_ctrl.sv
// Module: ea_ctrl
// Sequencer for the memory-indirect read: idle, or waiting for memory.
// Assumes: memory data is valid in the cycle in which mem_ready is high.
module ea_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_fetch,
    input  logic mem_ready,
    output logic fetching
);
    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} st_e;

    st_e st_q;

    // Enter the fetch state on an accepted indirect request; leave on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (start_fetch) st_q <= ST_FETCH;
                ST_FETCH: if (mem_ready)   st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign fetching = (st_q == ST_FETCH);
endmodule

// File: rtl/ea_gen_unit.sv
// Module: ea_gen_unit (top)
// Registers one request per acceptance and returns the operand or the
// effective address, with write-back for the auto-modify modes. An
// indirect request blocks intake until the memory read completes.
// Assumes: synchronous active-low reset; memory answers in a later cycle.
module ea_gen_unit
    import ea_gen_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31,
    parameter int STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_wide,
    input  logic              req_step_sel,
    input  logic              req_use_index,
    input  logic [DW-1:0]     reg_a,
    input  logic [DW-1:0]     reg_b,
    input  logic [DW-1:0]     konst,
    output logic              mem_rd_valid,
    output logic [DW-1:0]     mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              res_valid,
    output logic [KIND_W-1:0] res_kind,
    output logic [DW-1:0]     res_value,
    output logic              wb_en,
    output logic [DW-1:0]     wb_value
);
    logic [KIND_W-1:0] c_kind;
    logic [DW-1:0]     c_value;
    logic              c_wb_en;
    logic [DW-1:0]     c_wb_value;
    logic              c_fetch;
    logic [DW-1:0]     c_fetch_addr;
    logic              fetching;
    logic              accept;
    logic              wide_q;
    logic [DW-1:0]     faddr_q;
    logic [DW-1:0]     data_m;

    assign req_ready = !fetching;
    assign accept    = req_valid && req_ready;

    ea_calc #(.DW(DW), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .STEP(STEP)) u_calc (
        .mode       (req_mode),
        .wide       (req_wide),
        .step_sel   (req_step_sel),
        .use_index  (req_use_index),
        .reg_a      (reg_a),
        .reg_b      (reg_b),
        .konst      (konst),
        .kind       (c_kind),
        .value      (c_value),
        .wb_en      (c_wb_en),
        .wb_value   (c_wb_value),
        .is_fetch   (c_fetch),
        .fetch_addr (c_fetch_addr)
    );

    ea_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_fetch (accept && c_fetch),
        .mem_ready   (mem_rd_ready),
        .fetching    (fetching)
    );

    ea_mask #(.DW(DW), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_data_mask (
        .wide (wide_q),
        .in   (mem_rd_data),
        .out  (data_m)
    );

    // Hold the pointer and width of a pending indirect read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr_q <= '0;
            wide_q  <= 1'b0;
        end else if (accept && c_fetch) begin
            faddr_q <= c_fetch_addr;
            wide_q  <= req_wide;
        end
    end

    // Result register: single-cycle strobe per completed request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_kind  <= RK_REG;
            res_value <= '0;
            wb_en     <= 1'b0;
            wb_value  <= '0;
        end else begin
            res_valid <= 1'b0;
            wb_en     <= 1'b0;
            if (accept && !c_fetch) begin
                res_valid <= 1'b1;
                res_kind  <= c_kind;
                res_value <= c_value;
                wb_en     <= c_wb_en;
                wb_value  <= c_wb_value;
            end else if (fetching && mem_rd_ready) begin
                res_valid <= 1'b1;
                res_kind  <= RK_EA;
                res_value <= data_m;
            end
        end
    end

    assign mem_rd_valid = fetching;
    assign mem_rd_addr  = faddr_q;
endmodule

// File: rtl/ea_gen_unit_chk.sv
// Module: ea_gen_unit_chk
// Property checker bound to ea_gen_unit. It keeps the width bit of the
// last accepted request so that it can check the narrow mask.
module ea_gen_unit_chk #(
    parameter int DW       = 32,
    parameter int NARROW_W = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [3:0]    req_mode,
    input logic          req_wide,
    input logic          mem_rd_valid,
    input logic [DW-1:0] mem_rd_addr,
    input logic          mem_rd_ready,
    input logic          res_valid,
    input logic [1:0]    res_kind,
    input logic [DW-1:0] res_value,
    input logic          wb_en,
    input logic [DW-1:0] wb_value
);
    logic last_wide;

    // Record the width bit of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_wide <= 1'b0;
        else if (req_valid && req_ready) last_wide <= req_wide;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !res_valid && !wb_en && !mem_rd_valid);

    p_top_bit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd2) |-> !res_value[DW-1]);

    p_narrow_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd2 && !last_wide) |-> ((res_value >> NARROW_W) == '0));

    p_narrow_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !last_wide) |-> ((wb_value >> NARROW_W) == '0));

    p_wb_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> res_valid && res_kind == 2'd2);

    p_fetch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

    p_fetch_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> res_valid && !mem_rd_valid && !wb_en);

    p_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    p_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 4'd4) |=> res_valid);
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.DW(DW), .NARROW_W(NARROW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_mode     (req_mode),
    .req_wide     (req_wide),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_value    (res_value),
    .wb_en        (wb_en),
    .wb_value     (wb_value)
);

// File: tb/ea_gen_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every mode code, both widths, both step sources and both
// index settings over operands at the wrap points; expected values are
// computed arithmetically here.
module ea_gen_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_mode = '0;
    logic        req_wide = 1'b0;
    logic        req_step_sel = 1'b0;
    logic        req_use_index = 1'b0;
    logic [31:0] reg_a = '0;
    logic [31:0] reg_b = '0;
    logic [31:0] konst = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [31:0] res_value;
    logic        wb_en;
    logic [31:0] wb_value;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ea_gen_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_wide(req_wide), .req_step_sel(req_step_sel),
        .req_use_index(req_use_index), .reg_a(reg_a), .reg_b(reg_b), .konst(konst),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .res_valid(res_valid), .res_kind(res_kind), .res_value(res_value),
        .wb_en(wb_en), .wb_value(wb_value)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] amask(input logic w);
        return w ? 32'h7FFF_FFFF : 32'h00FF_FFFF;
    endfunction

    // Drive one request and check its outcome at the ports.
    task automatic run_one(input int m, input logic w, input logic ss, input logic ui,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] k, input int dly);
        logic [31:0] st;
        logic [31:0] msk;
        logic [1:0]  ek;
        logic [31:0] ev;
        logic        ewb;
        logic [31:0] ewv;
        logic [31:0] dat;
        msk = amask(w);
        st  = ss ? k : 32'd4;                               // R9
        ewb = 1'b0;
        ewv = 32'h0;
        case (m)
            1:  begin ek = 2'd1; ev = k; end                // R3
            2:  begin ek = 2'd2; ev = k & msk; end          // R4
            3:  begin ek = 2'd2; ev = a & msk; end          // R5
            5:  begin ek = 2'd2; ev = (a + st) & msk; ewb = 1'b1; ewv = ev; end   // R7
            6:  begin ek = 2'd2; ev = (a - st) & msk; ewb = 1'b1; ewv = ev; end   // R7
            7:  begin ek = 2'd2; ev = a & msk; ewb = 1'b1; ewv = (a + st) & msk; end // R8
            8:  begin ek = 2'd2; ev = a & msk; ewb = 1'b1; ewv = (a - st) & msk; end // R8
            9:  begin ek = 2'd2; ev = (a + (ui ? b : 32'h0) + k) & msk; end        // R10
            default: begin ek = 2'd0; ev = a; end           // R2
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_mode = 4'(m); req_wide = w; req_step_sel = ss;
        req_use_index = ui; reg_a = a; reg_b = b; konst = k;
        if (m != 4) begin
            @(negedge clk);
            req_valid = 1'b0;
            check(res_valid === 1'b1, "R12 result strobe", {31'h0, res_valid}, 32'h1);
            check(res_kind === ek, $sformatf("R2/R3/R4/R5 kind mode=%0d", m), {30'h0, res_kind}, {30'h0, ek});
            check(res_value === ev, $sformatf("R6/R7/R8/R10 value mode=%0d wide=%0d", m, w), res_value, ev);
            check(wb_en === ewb, $sformatf("R7/R8 wb_en mode=%0d", m), {31'h0, wb_en}, {31'h0, ewb});
            if (ewb)
                check(wb_value === ewv, $sformatf("R8 wb_value mode=%0d wide=%0d", m, w), wb_value, ewv);
            @(negedge clk);
            check(res_valid === 1'b0, "R12 single strobe", {31'h0, res_valid}, 32'h0);
        end else begin
            dat = a ^ 32'hA5A5_5A5A;
            @(negedge clk);
            req_mode = 4'd0;   // R12: register-mode request held during fetch
            check(mem_rd_valid === 1'b1, "R11 read issued", {31'h0, mem_rd_valid}, 32'h1);
            check(mem_rd_addr === (k & msk), "R11 read address", mem_rd_addr, k & msk);
            check(req_ready === 1'b0, "R12 intake blocked", {31'h0, req_ready}, 32'h0);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                check(res_valid === 1'b0 && mem_rd_valid === 1'b1, "R12 request ignored while fetching",
                      {30'h0, res_valid, mem_rd_valid}, 32'h1);
                check(mem_rd_addr === (k & msk), "R11 address held", mem_rd_addr, k & msk);
            end
            req_valid = 1'b0;
            mem_rd_ready = 1'b1;
            mem_rd_data = dat;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            check(res_valid === 1'b1 && res_kind === 2'd2 && wb_en === 1'b0, "R11 result after ready",
                  {29'h0, res_valid, res_kind}, 32'h6);
            check(res_value === (dat & msk), "R11 R6 fetched address masked", res_value, dat & msk);
            check(mem_rd_valid === 1'b0, "R11 read released", {31'h0, mem_rd_valid}, 32'h0);
            @(negedge clk);
            check(res_valid === 1'b0, "R12 single strobe after fetch", {31'h0, res_valid}, 32'h0);
        end
    endtask

    initial begin
        logic [31:0] vals [5];
        vals[0] = 32'h0000_0000;
        vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h00FF_FFFE;
        vals[3] = 32'h7FFF_FFFD;
        vals[4] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0 && wb_en === 1'b0, "R1 outputs quiet", {30'h0, res_valid, wb_en}, 32'h0);
        check(mem_rd_valid === 1'b0, "R1 no read", {31'h0, mem_rd_valid}, 32'h0);
        check(req_ready === 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
        for (int m = 0; m < 16; m++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++)
                    for (int u = 0; u < 2; u++)
                        for (int v = 0; v < 5; v++)
                            run_one(m, w[0], s[0], u[0], vals[v],
                                    {vals[v][15:0], vals[v][31:16]} ^ 32'h0F0F_0003,
                                    vals[(v + 1) % 5], v % 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule